// File: doc/BRIEF.md
# DDR2 Read Latency Sequencer

This block reproduces the device-side timing of a DDR2 read so that a controller bench or a behavioural memory model can place read data on the right clock. A mode load programs the CAS latency from a 3-bit code and a posted additive latency from a separate 3-bit value. Each accepted read strobe then produces, exactly AL + CL clocks later, a two-cycle data-valid window carrying a four-beat burst, with a beat-pair index telling the consumer which even/odd pair belongs to each cycle.

All delays are whole clocks. The block watches its own programming: reserved CAS codes, additive latencies above the legal limit, mode loads that would disturb a read still in flight, and reads that would overlap the previous burst are all refused and reported on a one-cycle error pulse. A refused read never produces a data-valid window.

Top module: `ddr2_read_latency_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `data_valid`, `beat_pair` and `rd_error` are 0; the latency after reset is CL = 3, AL = 0 with a valid configuration.
- R2: The CAS code maps 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 to CL = 3, 4, 5, 6 and 7 clocks; with AL = 0, a read registered at edge k makes `data_valid` rise after edge k + CL.
- R3: A programmed AL of 0 to 4 is added to CL, so the first valid cycle follows edge k + AL + CL.
- R4: Each accepted read yields exactly two consecutive `data_valid` cycles, `beat_pair` = 0 in the first and 1 in the second.
- R5: A mode load with CAS code 3'b000, 3'b001 or 3'b010, or with AL above 4, raises `rd_error` after the load edge and leaves the configuration invalid; every later read then raises `rd_error` and produces no `data_valid`.
- R6: Reads issued every second clock are all accepted and give an unbroken `data_valid` run with `beat_pair` alternating 0, 1.
- R7: A read on the edge right after an accepted read is refused: `rd_error` pulses after that edge, no window is made for it, and the earlier burst is unaffected.
- R8: A mode load on an edge where `rd_cmd` is also high, or where an accepted read has not yet reached the edge that registers its second valid cycle, is refused with an `rd_error` pulse and leaves the latency unchanged.
- R9: A legal mode load on an idle edge raises no error, takes effect for the next read, and makes an invalid configuration valid again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all activity on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mrs_load | input | 1 | Mode load strobe |
| mrs_cl_code | input | 3 | CAS latency code for the load |
| mrs_al | input | 3 | Additive latency for the load |
| rd_cmd | input | 1 | Registered read command strobe |
| data_valid | output | 1 | Read burst data window |
| beat_pair | output | 1 | 0 for beats 0/1, 1 for beats 2/3 |
| rd_error | output | 1 | One-cycle pulse on any refused load or read |

## Verification
The error pulse for a load or read driven before edge k is due in the cycle after edge k, and the two valid cycles of an accepted read are due after edges k + AL + CL and k + AL + CL + 1. The bench keeps a reference model that, whenever it drives an edge, writes these expected values into a ring indexed by the edge number they belong to; after every edge it reads back the slot for that edge at the falling clock and compares all three outputs. Directed sequences sweep every CAS code, the AL limits, back-to-back and colliding reads and refused loads, and a seeded random mix covers their interleavings.

// File: rtl/ddr2rl_pkg.sv
package ddr2rl_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned CL_MIN = 3;
  localparam int unsigned CL_MAX = 7;

  typedef logic [CODE_W-1:0] lat_code_t;

  // Codes below the minimum CAS latency are reserved; legal codes equal their CL.
  function automatic logic code_is_legal(input lat_code_t c);
    return int'(c) >= int'(CL_MIN);
  endfunction
endpackage

// File: rtl/ddr2rl_mode_reg.sv
module ddr2rl_mode_reg
  import ddr2rl_pkg::*;
#(
  parameter int unsigned AL_MAX = 4,
  parameter int unsigned LAT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  lat_code_t        code,
  input  logic [2:0]       al_in,
  input  logic             busy,
  output logic [LAT_W-1:0] lat,
  output logic             cfg_ok,
  output logic             load_take,
  output logic             load_err
);
  lat_code_t  cl_q;
  logic [2:0] al_q;
  logic       ok_q;
  logic       legal;

  always_comb begin
    legal     = code_is_legal(code) && (int'(al_in) <= int'(AL_MAX));
    load_take = load && !busy;
    load_err  = load && (busy || !legal);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_q <= lat_code_t'(CL_MIN);
      al_q <= '0;
      ok_q <= 1'b1;
    end else if (load_take) begin
      cl_q <= code;
      al_q <= al_in;
      ok_q <= legal;
    end
  end

  assign lat    = LAT_W'(cl_q) + LAT_W'(al_q);
  assign cfg_ok = ok_q;

  // A valid configuration never holds a reserved code or an out-of-range AL.
  assert_cfg_legal_R5: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (int'(cl_q) >= int'(CL_MIN)) && (int'(al_q) <= int'(AL_MAX)));

  // A load while busy leaves the latency untouched.
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (load && busy) |=> ($stable(cl_q) && $stable(al_q) && $stable(ok_q)));
endmodule

// File: rtl/ddr2rl_delay_line.sv
module ddr2rl_delay_line #(
  parameter int unsigned DEPTH = 13,
  parameter int unsigned LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             launch,
  input  logic [LAT_W-1:0] lat,
  output logic             dv_next,
  output logic             beat_next,
  output logic             in_flight,
  output logic             recent
);
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst || clear) pipe_q <= '0;
    else              pipe_q <= {pipe_q[DEPTH-2:0], launch};
  end

  // Tap selection by comparison keeps every index inside the line.
  always_comb begin
    dv_next   = 1'b0;
    beat_next = 1'b0;
    in_flight = 1'b0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (pipe_q[i] && ((i + 1 == int'(lat)) || (i == int'(lat)))) dv_next = 1'b1;
      if (pipe_q[i] && (i == int'(lat)))                          beat_next = 1'b1;
      if (pipe_q[i] && (i <= int'(lat)))                          in_flight = 1'b1;
    end
    recent = pipe_q[0];
  end

  // Two launches on adjacent edges never coexist in the line.
  assert_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pipe_q[1:0]));
endmodule

// File: rtl/ddr2_read_latency_seq.sv
module ddr2_read_latency_seq
  import ddr2rl_pkg::*;
#(
  parameter int unsigned AL_MAX = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mrs_load,
  input  logic [2:0] mrs_cl_code,
  input  logic [2:0] mrs_al,
  input  logic       rd_cmd,
  output logic       data_valid,
  output logic       beat_pair,
  output logic       rd_error
);
  localparam int unsigned DEPTH = AL_MAX + CL_MAX + 2;
  localparam int unsigned LAT_W = $clog2(DEPTH + 1);

  logic [LAT_W-1:0] lat;
  logic cfg_ok, load_take, load_err;
  logic dv_next, beat_next, in_flight, recent;
  logic rd_take, err_d;
  logic dv_q, beat_q, err_q;

  ddr2rl_mode_reg #(.AL_MAX(AL_MAX), .LAT_W(LAT_W)) i_mode (
    .clk(clk), .rst(rst), .load(mrs_load), .code(mrs_cl_code), .al_in(mrs_al),
    .busy(in_flight || rd_cmd), .lat(lat), .cfg_ok(cfg_ok),
    .load_take(load_take), .load_err(load_err)
  );

  ddr2rl_delay_line #(.DEPTH(DEPTH), .LAT_W(LAT_W)) i_line (
    .clk(clk), .rst(rst), .clear(load_take), .launch(rd_take), .lat(lat),
    .dv_next(dv_next), .beat_next(beat_next), .in_flight(in_flight), .recent(recent)
  );

  always_comb begin
    rd_take = rd_cmd && cfg_ok && !recent;
    err_d   = (rd_cmd && !rd_take) || load_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q   <= 1'b0;
      beat_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      dv_q   <= dv_next;
      beat_q <= beat_next;
      err_q  <= err_d;
    end
  end

  assign data_valid = dv_q;
  assign beat_pair  = beat_q;
  assign rd_error   = err_q;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!data_valid && !beat_pair && !rd_error));

  assert_pair_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !beat_pair) |=> (data_valid && beat_pair));

  assert_beat_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    beat_pair |-> data_valid);

  assert_bad_cfg_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && !cfg_ok) |=> rd_error);
endmodule

// File: tb/test_ddr2_read_latency_seq.sv
`timescale 1ns/1ps
module test_ddr2_read_latency_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mrs_load = 1'b0;
  logic [2:0] mrs_cl_code = 3'd0;
  logic [2:0] mrs_al = 3'd0;
  logic rd_cmd = 1'b0;
  logic data_valid, beat_pair, rd_error;

  always #5 clk = ~clk;

  ddr2_read_latency_seq i_ddr2_read_latency_seq (
    .clk(clk), .rst(rst), .mrs_load(mrs_load), .mrs_cl_code(mrs_cl_code),
    .mrs_al(mrs_al), .rd_cmd(rd_cmd), .data_valid(data_valid),
    .beat_pair(beat_pair), .rd_error(rd_error)
  );

  int n_cmp = 0, n_bad = 0, now = 0;
  bit exp_dv[64], exp_bt[64], exp_er[64];
  int m_cl = 3, m_al = 0, m_last = 0;
  bit m_ok = 1, m_have = 0;
  string tag = "R1";
  bit done = 0;

  task automatic cmp1(string what, bit got, bit want);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s edge %0d %s got %0b expected %0b", tag, now, what, got, want);
    end
  endtask

  task automatic check_now();
    int ix = now % 64;
    cmp1("data_valid", data_valid, exp_dv[ix]);
    cmp1("beat_pair", beat_pair, exp_bt[ix]);
    cmp1("rd_error", rd_error, exp_er[ix]);
    exp_dv[ix] = 0; exp_bt[ix] = 0; exp_er[ix] = 0;
  endtask

  // Reference model for the edge e that registers the given inputs.
  task automatic model_edge(bit ld, int code, int al, bit rd, int e);
    int lat = m_cl + m_al;
    bit busy = m_have && (e <= m_last + lat + 1);
    bit rec = m_have && (m_last == e - 1);
    bit take = rd && m_ok && !rec;
    bit err = rd && !take;
    if (ld) begin
      if (busy || rd) err = 1;
      else begin
        m_cl = code; m_al = al;
        m_ok = (code >= 3) && (al <= 4);
        if (!m_ok) err = 1;
        m_have = 0;
      end
    end
    if (take) begin
      exp_dv[(e + lat) % 64] = 1;
      exp_dv[(e + lat + 1) % 64] = 1;
      exp_bt[(e + lat + 1) % 64] = 1;
      m_last = e; m_have = 1;
    end
    exp_er[e % 64] = err;
  endtask

  task automatic step(bit ld, int code, int al, bit rd);
    @(negedge clk);
    check_now();
    mrs_load = ld; mrs_cl_code = 3'(code); mrs_al = 3'(al); rd_cmd = rd;
    model_edge(ld, code, al, rd, now + 1);
    now++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    // R1: reset state
    tag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cmp1("data_valid", data_valid, 0);
      cmp1("rd_error", rd_error, 0);
    end
    rst = 0;
    now = 0;
    idle(2);
    tag = "R1"; step(0, 0, 0, 1); idle(6);          // default latency 3
    // R2: every CAS code with AL = 0
    tag = "R2";
    for (int c = 3; c <= 7; c++) begin
      step(1, c, 0, 0); idle(1); step(0, 0, 0, 1); idle(12);
    end
    // R3: additive latency limits
    tag = "R3";
    step(1, 7, 4, 0); step(0, 0, 0, 1); idle(14);
    step(1, 3, 2, 0); step(0, 0, 0, 1); idle(8);
    // R6: back-to-back reads every second clock
    tag = "R6";
    for (int i = 0; i < 4; i++) begin step(0, 0, 0, 1); step(0, 0, 0, 0); end
    idle(10);
    // R7: read on the following edge is refused
    tag = "R7";
    step(0, 0, 0, 1); step(0, 0, 0, 1); idle(10);
    // R8: loads while busy or alongside a read
    tag = "R8";
    step(0, 0, 0, 1); step(0, 0, 0, 0); step(1, 6, 0, 0); idle(3);
    step(1, 4, 1, 0); idle(10);
    step(1, 6, 0, 1); idle(10);
    // R5: reserved codes and excessive AL
    tag = "R5";
    for (int c = 0; c <= 2; c++) begin
      step(1, c, 0, 0); idle(1); step(0, 0, 0, 1); idle(14);
    end
    step(1, 4, 5, 0); idle(1); step(0, 0, 0, 1); idle(14);
    // R9: legal load repairs the configuration
    tag = "R9";
    step(1, 5, 1, 0); idle(1); step(0, 0, 0, 1); idle(10);
    // Random mix
    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      bit rd = ($urandom % 3) == 0;
      bit ld = ($urandom % 25) == 0;
      step(ld, int'($urandom % 8), int'($urandom % 6), rd);
    end
    idle(16);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at edge %0d", now);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule